// File: doc/BRIEF.md
# Buffered Two-by-Two Self-Routing Switching Element

This block is one node of a multi-stage self-routing cell fabric. It has two inlets and two outlets. Each inlet holds a single cell. Each outlet has a first-in first-out queue of `DEPTH` cells. A cell carries a routing tag and a payload word. Bit 0 of the tag picks the outlet. That bit is then shifted away, so the next stage sees its own steering bit in position 0.

All movement is slotted and store-and-forward. A one-cycle `slot_start` strobe marks each slot boundary. On a strobe edge three kinds of transfer happen together:
- an outlet head leaves to the next stage if that stage reports it can accept it;
- an inlet cell moves into its outlet queue if there is room;
- a cell from the previous stage is loaded into a free inlet.

Room is counted after the departures of the same slot, so a full buffer can take a cell in the slot its head leaves. When both inlets want the same outlet and only one place is free, a free-running pseudo-random bit picks the cell that moves. The other cell waits in its inlet and tries again in the next slot. Ready signals in both directions give backpressure, so a cell that has entered the element is never dropped.

Top module: `bse_switch_elem`

## Requirements
- R1: A cell whose tag bit 0 is 0 is placed in outlet 0 (upper). A cell whose tag bit 0 is 1 is placed in outlet 1 (lower).
- R2: A cell leaves the element with its tag shifted right by one, with a 0 entering the most significant bit. Its payload is unchanged.
- R3: Each inlet holds at most one cell and each outlet queue holds at most `DEPTH` cells. No cell is lost or duplicated, and each outlet delivers cells in the order they entered it. When both inlets enter the same outlet in one slot, the inlet 0 cell is placed ahead of the inlet 1 cell.
- R4: State changes only on a clock edge where `slot_start` is 1. A cell moves at most one buffer per slot. A cell loaded into an inlet at slot k is first visible at an outlet after slot k+1.
- R5: Free space is counted after the same slot's departures. A full outlet queue whose head leaves accepts a cell in that slot. `in_ready` is 1 when the inlet is empty or its cell advances in this slot.
- R6: When its outlet has no room, an inlet cell stays in place with its tag and payload unchanged. `in_ready` for that inlet is 0, and the cell retries in the next slot.
- R7: When both inlets hold cells for the same outlet and exactly one place is free, exactly one of them advances. The winner is chosen by a pseudo-random bit, and over time either inlet can win.
- R8: An outlet head leaves only on a slot where its `out_ready` is 1. Otherwise `out_valid`, `out_tag` and `out_data` hold their values.
- R9: After reset every buffer is empty: `out_valid` is 0 and `in_ready` is 1 on both inlets.
- R10: Cells bound for different outlets advance independently. Two cells bound for the same outlet both advance when it has two or more free places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_start | input | 1 | One-cycle slot boundary strobe |
| in_valid | input | 2 | Previous stage offers a cell, one bit per inlet |
| in_tag | input | 2*TAG_W | Routing tags; inlet i at bits [i*TAG_W +: TAG_W] |
| in_data | input | 2*PAY_W | Payload words; inlet i at bits [i*PAY_W +: PAY_W] |
| in_ready | output | 2 | Inlet can take a cell on this slot |
| out_valid | output | 2 | Outlet queue head present, one bit per outlet |
| out_tag | output | 2*TAG_W | Stripped tag of each outlet head |
| out_data | output | 2*PAY_W | Payload of each outlet head |
| out_ready | input | 2 | Next-stage inlet can take a cell, one bit per outlet |

## Verification
The sharpest overlap is a departure from a full outlet queue in the same slot that two inlet cells compete for the single place it frees. Here free-space accounting and random arbitration both decide the result. A hot-spot phase steers every tag to outlet 0 while `out_ready` toggles, which fills the queue and then frees one place at a time. The bench model requires exactly one `in_ready` in those slots and follows the winner the design reports. Later output order and a final drain with a count of every cell then show that no cell was lost or reordered, and tallies confirm that each inlet won at least once.

// File: rtl/bse_pkg.sv
package bse_pkg;
  // Pseudo-random generator shape shared by the element.
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // Galois right-shift step: a maximal-length sequence over nonzero states.
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    lfsr_step = s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

  // Meaning of the steering bit.
  typedef enum logic {DIR_UPPER = 1'b0, DIR_LOWER = 1'b1} dir_e;
endpackage

// File: rtl/bse_lfsr.sv
module bse_lfsr
  import bse_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  output logic rnd
);
  // An all-zero seed would lock the sequence; substitute a legal one.
  localparam logic [LFSR_W-1:0] START = (SEED == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : SEED;

  logic [LFSR_W-1:0] state;

  // Free-running: steps every clock, not only on slot strobes.
  always_ff @(posedge clk) begin
    if (rst) state <= START;
    else     state <= lfsr_step(state);
  end

  assign rnd = state[0];

  // R7: the random source must never collapse into the stuck state
  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (rst) state != '0)
    else $error("random source reached all-zero state");
endmodule

// File: rtl/bse_inlet_buf.sv
module bse_inlet_buf #(
  parameter int TAG_W = 3,
  parameter int PAY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot,
  input  logic             load,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [PAY_W-1:0] load_data,
  input  logic             advance,
  output logic             valid,
  output logic [TAG_W-1:0] tag,
  output logic [PAY_W-1:0] data
);
  // Occupancy flag is reset; the cell fields need no reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
    end else if (slot) begin
      if (load)         valid <= 1'b1;
      else if (advance) valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (slot && load) begin
      tag  <= load_tag;
      data <= load_data;
    end
  end

  // R6: a blocked cell is neither dropped nor overwritten
  assert_blocked_cell_held_R6: assert property (@(posedge clk) disable iff (rst)
    (slot && valid && !advance) |=> (valid && $stable(tag) && $stable(data)))
    else $error("blocked inlet cell changed");

  // R4: without a strobe the inlet is frozen
  assert_inlet_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !slot |=> $stable(valid))
    else $error("inlet changed outside a slot boundary");
endmodule

// File: rtl/bse_outlet_fifo.sv
module bse_outlet_fifo #(
  parameter int W     = 19,
  parameter int DEPTH = 4,   // at least 2
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot,
  input  logic          push_a,
  input  logic [W-1:0]  cell_a,
  input  logic          push_b,
  input  logic [W-1:0]  cell_b,
  input  logic          pop_req,
  output logic          head_valid,
  output logic [W-1:0]  head_cell,
  output logic [CW-1:0] space
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    step = (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [PW-1:0] wr_nxt1, wr_nxt2;
  logic          can_pop, pop;

  assign wr_nxt1    = step(wr_ptr);
  assign wr_nxt2    = step(wr_nxt1);
  assign head_valid = (count != '0);
  assign head_cell  = mem[rd_ptr];
  assign can_pop    = head_valid && pop_req;
  assign pop        = slot && can_pop;
  // Places free once this slot's departure is counted.
  assign space      = CW'(DEPTH) - count + CW'(can_pop);

  // Storage: no reset, written only on slot strobes.
  always_ff @(posedge clk) begin
    if (slot) begin
      if (push_a) mem[wr_ptr] <= cell_a;
      if (push_b) mem[push_a ? wr_nxt1 : wr_ptr] <= cell_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (slot) begin
      if (pop) rd_ptr <= step(rd_ptr);
      if (push_a && push_b)     wr_ptr <= wr_nxt2;
      else if (push_a || push_b) wr_ptr <= wr_nxt1;
      count <= count + CW'(push_a) + CW'(push_b) - CW'(pop);
    end
  end

  // R3: pushes never exceed capacity
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (slot && (push_a || push_b)) |->
      ((int'(count) + int'(push_a) + int'(push_b) - int'(pop)) <= DEPTH))
    else $error("outlet queue overflow");

  // R4: queue is frozen between slot strobes
  assert_fifo_idle_R4: assert property (@(posedge clk) disable iff (rst)
    !slot |=> ($stable(count) && $stable(rd_ptr) && $stable(wr_ptr)))
    else $error("outlet queue changed outside a slot boundary");

  // R8: a head without permission to leave stays put
  assert_head_held_R8: assert property (@(posedge clk) disable iff (rst)
    (head_valid && !(slot && pop_req)) |=> (head_valid && $stable(head_cell)))
    else $error("outlet head changed without departure");
endmodule

// File: rtl/bse_arbiter.sv
module bse_arbiter
  import bse_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic [1:0]         req_v,
  input  logic [1:0]         req_dir,
  input  logic [1:0][CW-1:0] space,
  input  logic               rnd,
  output logic [1:0]         grant
);
  logic [1:0] g_in0, g_in1;   // per outlet: grant to inlet 0 / inlet 1

  for (genvar o = 0; o < 2; o++) begin : g_outlet
    logic want0, want1, ga, gb;
    assign want0 = req_v[0] && (req_dir[0] == 1'(o));
    assign want1 = req_v[1] && (req_dir[1] == 1'(o));

    always_comb begin
      ga = 1'b0;
      gb = 1'b0;
      if (want0 && want1) begin
        if (space[o] >= CW'(2)) begin
          ga = 1'b1;
          gb = 1'b1;
        end else if (space[o] == CW'(1)) begin
          ga = !rnd;
          gb = rnd;
        end
      end else begin
        ga = want0 && (space[o] != '0);
        gb = want1 && (space[o] != '0);
      end
    end

    assign g_in0[o] = ga;
    assign g_in1[o] = gb;
  end

  assign grant[0] = |g_in0;
  assign grant[1] = |g_in1;
endmodule

// File: rtl/bse_switch_elem.sv
module bse_switch_elem
  import bse_pkg::*;
#(
  parameter int                TAG_W = 3,
  parameter int                PAY_W = 16,
  parameter int                DEPTH = 4,
  parameter logic [LFSR_W-1:0] SEED  = 16'hACE1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 slot_start,
  input  logic [1:0]           in_valid,
  input  logic [2*TAG_W-1:0]   in_tag,
  input  logic [2*PAY_W-1:0]   in_data,
  output logic [1:0]           in_ready,
  output logic [1:0]           out_valid,
  output logic [2*TAG_W-1:0]   out_tag,
  output logic [2*PAY_W-1:0]   out_data,
  input  logic [1:0]           out_ready
);
  localparam int CELL_W = TAG_W + PAY_W;
  localparam int CW     = $clog2(DEPTH + 1);

  logic [1:0]         ib_valid;
  logic [TAG_W-1:0]   ib_tag  [2];
  logic [PAY_W-1:0]   ib_data [2];
  logic [1:0]         ib_dir;
  logic [1:0]         grant;
  logic [1:0][CW-1:0] space;
  logic               rnd;
  logic [CELL_W-1:0]  fwd_cell [2];

  bse_lfsr #(.SEED(SEED)) u_rand (.clk(clk), .rst(rst), .rnd(rnd));

  // Inlet buffers: one cell each.
  for (genvar i = 0; i < 2; i++) begin : g_inlet
    bse_inlet_buf #(.TAG_W(TAG_W), .PAY_W(PAY_W)) u_ib (
      .clk      (clk),
      .rst      (rst),
      .slot     (slot_start),
      .load     (in_valid[i] && in_ready[i]),
      .load_tag (in_tag[i*TAG_W +: TAG_W]),
      .load_data(in_data[i*PAY_W +: PAY_W]),
      .advance  (grant[i]),
      .valid    (ib_valid[i]),
      .tag      (ib_tag[i]),
      .data     (ib_data[i])
    );
    assign ib_dir[i]   = ib_tag[i][0];
    // Steering bit consumed here; zero fills the top.
    assign fwd_cell[i] = {ib_tag[i] >> 1, ib_data[i]};
    assign in_ready[i] = !ib_valid[i] || grant[i];
  end

  bse_arbiter #(.CW(CW)) u_arb (
    .req_v  (ib_valid),
    .req_dir(ib_dir),
    .space  (space),
    .rnd    (rnd),
    .grant  (grant)
  );

  // Outlet queues: inlet 0 is always written ahead of inlet 1.
  for (genvar o = 0; o < 2; o++) begin : g_outlet
    logic [CELL_W-1:0] head;
    logic              hv;
    bse_outlet_fifo #(.W(CELL_W), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .slot      (slot_start),
      .push_a    (grant[0] && (ib_dir[0] == 1'(o))),
      .cell_a    (fwd_cell[0]),
      .push_b    (grant[1] && (ib_dir[1] == 1'(o))),
      .cell_b    (fwd_cell[1]),
      .pop_req   (out_ready[o]),
      .head_valid(hv),
      .head_cell (head),
      .space     (space[o])
    );
    assign out_valid[o]               = hv;
    assign out_tag[o*TAG_W +: TAG_W]  = head[CELL_W-1:PAY_W];
    assign out_data[o*PAY_W +: PAY_W] = head[PAY_W-1:0];
  end

  // R1: an inlet 0 cell steered upward appears at the upper outlet
  assert_route_upper_R1: assert property (@(posedge clk) disable iff (rst)
    (slot_start && grant[0] && (ib_dir[0] == DIR_UPPER)) |=> out_valid[0])
    else $error("upper-steered cell missing at outlet 0");

  // R1: an inlet 1 cell steered downward appears at the lower outlet
  assert_route_lower_R1: assert property (@(posedge clk) disable iff (rst)
    (slot_start && grant[1] && (ib_dir[1] == DIR_LOWER)) |=> out_valid[1])
    else $error("lower-steered cell missing at outlet 1");

  // R7: single free place under contention admits exactly one cell
  assert_single_winner_R7: assert property (@(posedge clk) disable iff (rst)
    ((ib_valid == 2'b11) && (ib_dir[0] == ib_dir[1]) && (space[ib_dir[0]] == CW'(1)))
      |-> ($countones(grant) == 1))
    else $error("contention for one place not resolved to one winner");

  // R6: no advance into an outlet without room
  assert_no_room_no_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (ib_valid[0] && (space[ib_dir[0]] == '0)) |-> !grant[0])
    else $error("inlet 0 granted into a full outlet");
endmodule

// File: tb/bse_switch_elem_test.sv
`timescale 1ns/1ps
module bse_switch_elem_test;
  localparam int TAG_W = 3;
  localparam int PAY_W = 16;
  localparam int DEPTH = 4;
  localparam int CELL_W = TAG_W + PAY_W;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                slot_start = 1'b0;
  logic [1:0]          in_valid = '0;
  logic [2*TAG_W-1:0]  in_tag = '0;
  logic [2*PAY_W-1:0]  in_data = '0;
  logic [1:0]          in_ready;
  logic [1:0]          out_valid;
  logic [2*TAG_W-1:0]  out_tag;
  logic [2*PAY_W-1:0]  out_data;
  logic [1:0]          out_ready = '0;

  always #2 clk = ~clk;   // 250 MHz

  bse_switch_elem #(.TAG_W(TAG_W), .PAY_W(PAY_W), .DEPTH(DEPTH), .SEED(16'hACE1)) uut (
    .clk(clk), .rst(rst), .slot_start(slot_start),
    .in_valid(in_valid), .in_tag(in_tag), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data), .out_ready(out_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model state
  bit                m_iv   [2];
  logic [TAG_W-1:0]  m_itag [2];
  logic [PAY_W-1:0]  m_idat [2];
  logic [CELL_W-1:0] q0[$];
  logic [CELL_W-1:0] q1[$];
  // Previous-stage offers
  bit                p_v    [2];
  logic [TAG_W-1:0]  p_tag  [2];
  logic [PAY_W-1:0]  p_dat  [2];
  int seq = 0, delivered = 0;
  int contentions = 0, wins0 = 0, wins1 = 0;
  bit hot = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int qsize(input int o);
    return (o == 0) ? q0.size() : q1.size();
  endfunction

  function automatic logic [CELL_W-1:0] qhead(input int o);
    return (o == 0) ? q0[0] : q1[0];
  endfunction

  // One clock: drive at negedge, check before the next posedge, advance model.
  task automatic step(input bit slot, input int p_new, input int p_ordy);
    bit exp_rdy [2];
    int sp [2];
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      if (!p_v[i] && ($urandom_range(99) < p_new)) begin
        p_v[i]   = 1'b1;
        p_tag[i] = TAG_W'($urandom_range((1 << TAG_W) - 1));
        if (hot) p_tag[i][0] = 1'b0;
        p_dat[i] = PAY_W'(seq);
        seq++;
      end
      in_valid[i]                = p_v[i];
      in_tag[i*TAG_W +: TAG_W]   = p_tag[i];
      in_data[i*PAY_W +: PAY_W]  = p_dat[i];
      out_ready[i]               = ($urandom_range(99) < p_ordy);
    end
    slot_start = slot;
    #1;
    // Outlet heads against the model (routing, stripping, order, hold)
    for (int o = 0; o < 2; o++) begin
      chk(out_valid[o] == (qsize(o) != 0), "R1", $sformatf("out_valid[%0d]", o),
          out_valid[o], qsize(o) != 0);
      if (qsize(o) != 0 && out_valid[o]) begin
        chk(out_tag[o*TAG_W +: TAG_W] == qhead(o)[CELL_W-1:PAY_W], "R2",
            $sformatf("out_tag[%0d]", o), out_tag[o*TAG_W +: TAG_W], qhead(o)[CELL_W-1:PAY_W]);
        chk(out_data[o*PAY_W +: PAY_W] == qhead(o)[PAY_W-1:0], "R3",
            $sformatf("out_data[%0d] order", o), out_data[o*PAY_W +: PAY_W], qhead(o)[PAY_W-1:0]);
      end
      sp[o] = DEPTH - qsize(o) + (((qsize(o) != 0) && out_ready[o]) ? 1 : 0);
    end
    // Expected inlet readiness
    if (m_iv[0] && m_iv[1] && (m_itag[0][0] == m_itag[1][0])) begin
      int d = int'(m_itag[0][0]);
      if (sp[d] >= 2) begin
        exp_rdy[0] = 1; exp_rdy[1] = 1;
        chk(in_ready == 2'b11, "R10", "both to one outlet with room", in_ready, 2'b11);
      end else if (sp[d] == 1) begin
        chk((in_ready[0] ^ in_ready[1]) == 1'b1, "R7", "single winner", in_ready, 2'b01);
        exp_rdy[0] = in_ready[0]; exp_rdy[1] = in_ready[1];
        if (slot) begin
          contentions++;
          if (in_ready[0]) wins0++; else wins1++;
        end
      end else begin
        exp_rdy[0] = 0; exp_rdy[1] = 0;
        chk(in_ready == 2'b00, "R6", "both blocked", in_ready, 2'b00);
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        exp_rdy[i] = !m_iv[i] || (sp[int'(m_itag[i][0])] >= 1);
        chk(in_ready[i] == exp_rdy[i], exp_rdy[i] ? "R5" : "R6",
            $sformatf("in_ready[%0d]", i), in_ready[i], exp_rdy[i]);
      end
    end
    if (slot) begin
      // Departures
      if (q0.size() != 0 && out_ready[0]) begin void'(q0.pop_front()); delivered++; end
      if (q1.size() != 0 && out_ready[1]) begin void'(q1.pop_front()); delivered++; end
      // Inlet to outlet, inlet 0 first
      for (int i = 0; i < 2; i++) begin
        if (m_iv[i] && exp_rdy[i]) begin
          if (m_itag[i][0] == 1'b0) q0.push_back({m_itag[i] >> 1, m_idat[i]});
          else                      q1.push_back({m_itag[i] >> 1, m_idat[i]});
          m_iv[i] = 0;
        end
      end
      // Arrivals from previous stage
      for (int i = 0; i < 2; i++) begin
        if (p_v[i] && exp_rdy[i]) begin
          m_iv[i] = 1; m_itag[i] = p_tag[i]; m_idat[i] = p_dat[i];
          p_v[i] = 0;
        end
      end
    end
  endtask

  // Offer one specific cell on one inlet
  task automatic offer(input int i, input logic [TAG_W-1:0] t);
    p_v[i] = 1; p_tag[i] = t; p_dat[i] = PAY_W'(seq); seq++;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    for (int i = 0; i < 2; i++) begin m_iv[i] = 0; p_v[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9: reset state
    chk(in_ready == 2'b11, "R9", "in_ready after reset", in_ready, 2'b11);
    chk(out_valid == 2'b00, "R9", "out_valid after reset", out_valid, 2'b00);

    // Directed: tag 110 on inlet 0 (upper), tag 011 on inlet 1 (lower). R1 R2 R4
    offer(0, 3'b110);
    offer(1, 3'b011);
    step(1, 0, 0);      // load into inlets
    step(0, 0, 0);      // idle cycles: nothing moves (R4)
    step(0, 0, 0);
    step(1, 0, 0);      // into outlets
    step(0, 0, 0);
    chk(out_tag[0 +: TAG_W] == 3'b011, "R2", "stripped upper tag", out_tag[0 +: TAG_W], 3'b011);
    chk(out_tag[TAG_W +: TAG_W] == 3'b001, "R2", "stripped lower tag", out_tag[TAG_W +: TAG_W], 3'b001);
    for (int k = 0; k < 4; k++) step(1, 0, 100);

    // Backpressure fill then release: R8, R6, R5
    hot = 1;
    for (int k = 0; k < 12; k++) step(1, 100, 0);
    for (int k = 0; k < 40; k++) step(1, 100, 50);
    // Hot spot with idle gaps between strobes: R7 contention, R4
    for (int k = 0; k < 300; k++) step(k % 3 == 0, 100, 60);
    hot = 0;
    // Mixed random traffic
    for (int k = 0; k < 3000; k++) step($urandom_range(3) != 0, 70, 65);
    // Drain everything: R3 no loss
    for (int k = 0; k < 60; k++) step(1, 0, 100);

    chk(delivered == seq, "R3", "cells delivered vs offered", delivered, seq);
    chk(contentions > 0 && wins0 > 0 && wins1 > 0, "R7", "both inlets win some contentions",
        {wins0[15:0], wins1[15:0]}, 1);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule